// File: doc/BRIEF.md
# Shared Issue-Queue Occupancy Allocator

This block tracks how many entries of one shared issue queue each hardware thread holds, and decides from that whether a thread may place another instruction into the queue. It does not store instructions. It holds one occupancy counter per thread and one global free-entry counter. From these counters, the current set of active threads and a static sharing-policy select, it derives a cap, a free count and a full flag for each thread, and a full flag for the whole queue.

Each cycle the front end may present one insert request tagged with a thread id. The back end may return entries for every thread at once. It does this through a commit count and a squash count per thread. The insert and all releases of a cycle are applied together as one net change at the clock edge. Caps are combinational in the active mask and the policy select, so they follow a mask change in the same cycle. When a cap shrinks below a thread's occupancy, the occupancy is left untouched.

Top module: `iq_share_alloc`

## Requirements
- R1: After reset every thread count is zero, `q_full` is 0, and each `thr_free` slice equals that thread's cap under the current policy and mask.
- R2: With `policy_sel` 2'b00 or 2'b11 (shared), every thread's cap is `DEPTH`.
- R3: With `policy_sel` 2'b01 (split), an active thread's cap is floor(`DEPTH` / number of set bits in `active_mask`). An inactive thread's cap, and every cap when the mask is zero, is floor(`DEPTH` / `NT`).
- R4: With `policy_sel` 2'b10 (percentage), every thread's cap is floor(`DEPTH` * `THRESH_PCT` / 100). The exception is when exactly one mask bit is set: that active thread's cap is then `DEPTH`.
- R5: Thread t's free count is its cap minus its count, saturating at zero. It appears at `thr_free[t*CW +: CW]`, with `CW` = clog2(`DEPTH`+1). `thr_full[t]` is 1 exactly when that free count is zero.
- R6: `q_full` is 1 exactly when the sum of all thread counts equals `DEPTH`. That sum never exceeds `DEPTH`.
- R7: An insert is accepted only when `ins_tid` is below `NT`, that thread is not full, and the queue is not full, judged on the state before the edge. An accepted insert adds one to that thread's count at the edge. A rejected insert changes no count.
- R8: At each edge the commit and squash counts of thread t are subtracted from its count after any accepted insert is added. A release larger than that sum leaves the count at zero. With no insert and no release, counts hold.
- R9: A change of `active_mask` or `policy_sel` changes caps and free counts in the same cycle and does not change any thread count.
- R10: The global free-entry register always equals `DEPTH` minus the sum of the thread counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 2 | Sharing policy: 00 shared, 01 split, 10 percentage, 11 shared |
| active_mask | input | NT | One bit per thread, 1 = thread active |
| ins_valid | input | 1 | Insert request this cycle |
| ins_tid | input | TW | Thread id of the insert request |
| commit_cnt | input | NT*CW | Per-thread count of entries released by commit, thread t at [t*CW +: CW] |
| squash_cnt | input | NT*CW | Per-thread count of entries released by squash, thread t at [t*CW +: CW] |
| thr_full | output | NT | Per-thread full flag |
| thr_free | output | NT*CW | Per-thread free count, thread t at [t*CW +: CW] |
| q_full | output | 1 | Whole queue full |

## Verification
The bench sweeps every mask under every policy select and compares each cap with a direct arithmetic formula. This catches a design that divides by the thread count instead of the active count, or that forgets the single-thread exception in percentage mode. Directed runs then fill a thread past its cap, and fill the whole queue past `DEPTH`. A design that judged acceptance after the same-cycle release, or that let an insert slip in while the queue was full, would show a count one higher than the model. Over-large releases and shrinking caps are driven on purpose: a design without saturation would wrap the count or the free value to a large number. A long pseudo-random run mixes all of these against the bench's own counter model.

// File: rtl/iq_share_alloc.sv
module iq_share_alloc #(
  parameter int NT         = 4,
  parameter int DEPTH      = 32,
  parameter int THRESH_PCT = 50,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy_sel,
  input  logic [NT-1:0]    active_mask,
  input  logic             ins_valid,
  input  logic [TW-1:0]    ins_tid,
  input  logic [NT*CW-1:0] commit_cnt,
  input  logic [NT*CW-1:0] squash_cnt,
  output logic [NT-1:0]    thr_full,
  output logic [NT*CW-1:0] thr_free,
  output logic             q_full
);

  localparam int THR_CAP    = (DEPTH * THRESH_PCT) / 100;
  localparam int BASE_SHARE = DEPTH / NT;

  logic [CW-1:0] cnt_q [NT];
  logic [CW-1:0] gfree_q;
  logic [CW-1:0] cap_w [NT];
  logic [CW:0]   relsat_w [NT];
  logic [CW-1:0] cnt_d [NT];
  logic [CW:0]   gfree_d;
  logic          acc;
  int            act_n;

  always_comb begin
    act_n = 0;
    for (int t = 0; t < NT; t++) act_n = act_n + int'(active_mask[t]);
  end

  assign q_full = (gfree_q == '0);
  assign acc = ins_valid && (int'(ins_tid) < NT) && !q_full &&
               !thr_full[int'(ins_tid) % NT];

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [CW:0] up_w;
    logic [CW:0] rel_w;

    always_comb begin
      unique case (policy_sel)
        2'b01:   cap_w[t] = (active_mask[t] && act_n != 0) ? CW'(DEPTH / act_n)
                                                           : CW'(BASE_SHARE);
        2'b10:   cap_w[t] = (active_mask[t] && act_n == 1) ? CW'(DEPTH)
                                                           : CW'(THR_CAP);
        default: cap_w[t] = CW'(DEPTH);
      endcase
    end

    assign thr_free[t*CW +: CW] = (cap_w[t] > cnt_q[t]) ? cap_w[t] - cnt_q[t] : '0;
    assign thr_full[t] = (thr_free[t*CW +: CW] == '0);

    assign up_w  = {1'b0, cnt_q[t]} + {{CW{1'b0}}, (acc && int'(ins_tid) == t)};
    assign rel_w = {1'b0, commit_cnt[t*CW +: CW]} + {1'b0, squash_cnt[t*CW +: CW]};
    assign relsat_w[t] = (rel_w > up_w) ? up_w : rel_w;
    assign cnt_d[t] = CW'(up_w - relsat_w[t]);

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[t] <= '0;
      else        cnt_q[t] <= cnt_d[t];
    end
  end

  always_comb begin
    gfree_d = {1'b0, gfree_q} - {{CW{1'b0}}, acc};
    for (int t = 0; t < NT; t++) gfree_d = gfree_d + relsat_w[t];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gfree_q <= CW'(DEPTH);
    else        gfree_q <= CW'(gfree_d);
  end

endmodule

// File: rtl/iq_share_alloc_chk.sv
module iq_share_alloc_chk #(
  parameter int NT    = 4,
  parameter int DEPTH = 32,
  parameter int CW    = 6,
  parameter int TW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       policy_sel,
  input logic             ins_valid,
  input logic [NT*CW-1:0] commit_cnt,
  input logic [NT*CW-1:0] squash_cnt,
  input logic [NT-1:0]    thr_full,
  input logic [NT*CW-1:0] thr_free,
  input logic             q_full,
  input logic [CW-1:0]    cnt_q [NT],
  input logic [CW-1:0]    gfree_q
);

  int occ_sum;

  always_comb begin
    occ_sum = 0;
    for (int t = 0; t < NT; t++) occ_sum = occ_sum + int'(cnt_q[t]);
  end

  // R10
  gfree_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gfree_q) == DEPTH - occ_sum);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_sum <= DEPTH);

  // R6
  qfull_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> occ_sum == DEPTH);

  for (genvar t = 0; t < NT; t++) begin : g_chk
    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_full[t] && commit_cnt[t*CW +: CW] == '0 && squash_cnt[t*CW +: CW] == '0)
      |=> cnt_q[t] <= $past(cnt_q[t]));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ins_valid && commit_cnt[t*CW +: CW] == '0 && squash_cnt[t*CW +: CW] == '0)
      |=> $stable(cnt_q[t]));

    // R5
    free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(thr_free[t*CW +: CW]) + int'(cnt_q[t]) <= DEPTH);

    // R2
    shared_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_sel == 2'b00) |-> int'(thr_free[t*CW +: CW]) + int'(cnt_q[t]) == DEPTH);
  end

endmodule

bind iq_share_alloc iq_share_alloc_chk #(.NT(NT), .DEPTH(DEPTH), .CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .ins_valid(ins_valid),
  .commit_cnt(commit_cnt), .squash_cnt(squash_cnt), .thr_full(thr_full),
  .thr_free(thr_free), .q_full(q_full), .cnt_q(cnt_q), .gfree_q(gfree_q)
);

// File: tb/tb_iq_share_alloc.sv
module tb_iq_share_alloc;
  localparam int NT = 4, DEPTH = 32, PCT = 50, CW = 6, TW = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0]       policy_sel;
  logic [NT-1:0]    active_mask;
  logic             ins_valid;
  logic [TW-1:0]    ins_tid;
  logic [NT*CW-1:0] commit_cnt, squash_cnt;
  logic [NT-1:0]    thr_full;
  logic [NT*CW-1:0] thr_free;
  logic             q_full;

  int checks = 0, fails = 0;
  int cnt_m[NT];
  bit finished = 1'b0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  iq_share_alloc #(.NT(NT), .DEPTH(DEPTH), .THRESH_PCT(PCT)) dut (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .active_mask(active_mask),
    .ins_valid(ins_valid), .ins_tid(ins_tid), .commit_cnt(commit_cnt),
    .squash_cnt(squash_cnt), .thr_full(thr_full), .thr_free(thr_free), .q_full(q_full)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int cap_of(int pol, int mask, int t);
    int n = 0;
    for (int i = 0; i < NT; i++) n += (mask >> i) & 1;
    if (pol == 1) return (((mask >> t) & 1) == 1 && n != 0) ? DEPTH / n : DEPTH / NT;
    if (pol == 2) return (((mask >> t) & 1) == 1 && n == 1) ? DEPTH : (DEPTH * PCT) / 100;
    return DEPTH;
  endfunction

  function automatic int exp_free(int t);
    int c = cap_of(int'(policy_sel), int'(active_mask), t);
    return (c > cnt_m[t]) ? c - cnt_m[t] : 0;
  endfunction

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    int tot = 0;
    for (int t = 0; t < NT; t++) begin
      check_val(tag, int'(thr_free[t*CW +: CW]), exp_free(t));
      check_val(tag, int'(thr_full[t]), int'(exp_free(t) == 0));
      tot += cnt_m[t];
    end
    check_val(tag, int'(q_full), int'(tot == DEPTH));
  endtask

  task automatic idle();
    ins_valid = 1'b0; ins_tid = '0; commit_cnt = '0; squash_cnt = '0;
  endtask

  task automatic step(string tag);
    int tot = 0, acc, up, r;
    for (int t = 0; t < NT; t++) tot += cnt_m[t];
    acc = int'(ins_valid && exp_free(int'(ins_tid)) > 0 && tot < DEPTH);
    for (int t = 0; t < NT; t++) begin
      up = cnt_m[t] + ((acc == 1 && int'(ins_tid) == t) ? 1 : 0);
      r = int'(commit_cnt[t*CW +: CW]) + int'(squash_cnt[t*CW +: CW]);
      cnt_m[t] = (r > up) ? 0 : up - r;
    end
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) cnt_m[t] = 0;
    idle();
    policy_sel = 2'b00;
    active_mask = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check_all("R1");

    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 16; m++) begin
        @(negedge clk);
        policy_sel = 2'(p);
        active_mask = 4'(m);
        #1 check_all(p == 1 ? "R3" : (p == 2 ? "R4" : "R2"));
      end

    @(negedge clk);
    policy_sel = 2'b01; active_mask = 4'b0011;
    ins_valid = 1'b1; ins_tid = 2'd0;
    repeat (20) step("R7 thread cap");
    commit_cnt[0 +: CW] = 6'd3; squash_cnt[0 +: CW] = 6'd2;
    step("R8 release with insert");
    idle(); ins_valid = 1'b1; commit_cnt[0 +: CW] = 6'd1;
    step("R8 net zero");
    idle(); commit_cnt[0 +: CW] = 6'd20; squash_cnt[0 +: CW] = 6'd9;
    step("R8 saturate");
    idle();
    step("R8 hold");

    ins_valid = 1'b1; ins_tid = 2'd1;
    repeat (10) step("R7 fill thread1");
    idle();
    active_mask = 4'b1111;
    #1 check_all("R9 cap shrink");
    step("R9 counts held");
    policy_sel = 2'b10; active_mask = 4'b0010;
    #1 check_all("R9 R4 single active");
    step("R9 counts held");

    policy_sel = 2'b00; active_mask = 4'b1111;
    commit_cnt = '1;
    step("R8 drain");
    idle(); ins_valid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      ins_tid = 2'(i % NT);
      step("R6 global fill");
    end
    idle(); squash_cnt[2*CW +: CW] = 6'd1; ins_valid = 1'b1; ins_tid = 2'd2;
    step("R7 full then release");
    idle();

    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[7:4] == 4'h0) active_mask = lfsr[11:8];
      if (lfsr[15:12] == 4'h0) policy_sel = lfsr[17:16];
      ins_valid = lfsr[18] | lfsr[19];
      ins_tid = lfsr[21:20];
      commit_cnt = '0; squash_cnt = '0;
      for (int t = 0; t < NT; t++) begin
        if (lfsr[22 + t] && lfsr[26]) commit_cnt[t*CW +: CW] = CW'(lfsr[28:27]);
        if (lfsr[22 + t] && lfsr[29] && lfsr[30]) squash_cnt[t*CW +: CW] = CW'(lfsr[31:30]);
      end
      step("R7 R8 mixed");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule